// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Block

This block holds the inter-processor interrupt state for a single core and drives that core's interrupt line. Software reaches it through a plain 32-bit register port (valid, write, address, data). Through this port it sets and clears pending interrupt bits, masks them with an enable word, exchanges data through an eight-word mailbox, and sends an interrupt to another core.

Pending bits can also arrive from other cores. A request port carries a bit mask, and that mask is merged into the pending word in the same cycle as any local set write. A write to the send register becomes an outgoing request that holds a target core number and a one-hot bit mask. The request stays on a valid/ready handshake until the multi-core fabric accepts it.

Top module: `core_ipi_block`

## Requirements
- R1: After reset the pending word, the enable word and every mailbox word read as zero, the interrupt output is low and no outgoing request is valid.
- R2: Only address bits 7:2 select a register, and higher bits are ignored. The word offsets are pending 0x00, enable 0x04, set 0x08, clear 0x0C, mailbox 0x20 to 0x3C, and send 0x40. A read at any other offset returns zero, and a write there changes nothing.
- R3: The pending word is read-only. Writing to offset 0x00 leaves it unchanged.
- R4: The set, clear and send offsets always read as zero.
- R5: A set event ORs its mask into the pending word. A set event is a write to offset 0x08, a valid incoming request, or both. At the edge that applies the event, the registered interrupt output goes high if the new pending word ANDed with the enable word is nonzero. Otherwise the output keeps its value.
- R6: A write to offset 0x0C clears the written bits from the pending word. The interrupt output falls only if the resulting pending word is all zero and the enable word is nonzero. Otherwise the output holds, even while it is masked.
- R7: A write to the enable word replaces it and does not by itself change the interrupt output.
- R8: The eight mailbox words are each readable and writable. The word index is address bits 4:2.
- R9: A write to offset 0x40 takes the target core from data bits 25:16 and the vector from bits 4:0. From the next edge it presents a valid outgoing request with that core number and a mask in which only bit <vector> is set.
- R10: A send whose target core number is greater than or equal to NUM_CORES is dropped and produces no request.
- R11: An outgoing request keeps its core and mask stable until it is accepted (valid and ready high at an edge). A send write is taken only when no request is pending or the pending one is accepted in the same cycle; otherwise it is dropped.
- R12: An incoming request mask and a local set write in the same cycle are ORed together. When a clear write meets an incoming set in the same cycle, the new pending word is (old AND NOT clear) OR set, so a bit named by both stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address, bits 7:2 decoded |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| in_set_valid | input | 1 | Incoming set request from another core |
| in_set_mask | input | 32 | Bits to OR into the pending word |
| out_set_valid | output | 1 | Outgoing set request valid |
| out_set_ready | input | 1 | Fabric accepts the outgoing request |
| out_set_core | output | clog2(NUM_CORES) | Target core number |
| out_set_mask | output | 32 | One-hot vector mask for the target |
| irq_o | output | 1 | Registered interrupt line for this core |

## Verification
Two functions can act on the pending word in the same cycle. One is a register write to set or clear. The other is an incoming request from another core. The bench drives both together: in directed steps, with set and clear masks that overlap the incoming mask, and throughout the random phase, where the incoming port fires on about a quarter of cycles regardless of register traffic. After each edge, the pending word, read back through the register port, and the interrupt output are compared with a bench model. That model applies clear before set and follows the asymmetric raise and drop rules. A send write that collides with an unaccepted request is also provoked, and the held request is checked to be unchanged.

// File: rtl/core_ipi_pkg.sv
package core_ipi_pkg;

   localparam int unsigned WORD_W = 32;

   // Word offsets (byte offset >> 2) within the decoded 8-bit window
   localparam logic [5:0] WOFS_PEND   = 6'h00;
   localparam logic [5:0] WOFS_ENABLE = 6'h01;
   localparam logic [5:0] WOFS_SET    = 6'h02;
   localparam logic [5:0] WOFS_CLEAR  = 6'h03;
   localparam logic [5:0] WOFS_SEND   = 6'h10;
   localparam logic [2:0] WOFS_MBOX_HI = 3'b001;   // words 0x08..0x0F

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PEND,
      SEL_ENABLE,
      SEL_SET,
      SEL_CLEAR,
      SEL_MBOX,
      SEL_SEND
   } reg_sel_e;

   function automatic reg_sel_e decode_word(input logic [5:0] widx);
      reg_sel_e sel;
      sel = SEL_NONE;
      if (widx == WOFS_PEND)              sel = SEL_PEND;
      else if (widx == WOFS_ENABLE)       sel = SEL_ENABLE;
      else if (widx == WOFS_SET)          sel = SEL_SET;
      else if (widx == WOFS_CLEAR)        sel = SEL_CLEAR;
      else if (widx == WOFS_SEND)         sel = SEL_SEND;
      else if (widx[5:3] == WOFS_MBOX_HI) sel = SEL_MBOX;
      return sel;
   endfunction

endpackage

// File: rtl/core_ipi_pending.sv
module core_ipi_pending #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_evt,
   input  logic [W-1:0] set_mask,
   input  logic         clr_evt,
   input  logic [W-1:0] clr_mask,
   input  logic         en_we,
   input  logic [W-1:0] en_wdata,
   output logic [W-1:0] pending,
   output logic [W-1:0] enable,
   output logic         irq
);

   generate
      if (W < 1) begin : g_bad_width
         $error("core_ipi_pending: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] pend_nxt;
   logic         irq_nxt;

   // clear applies first, then set bits are merged in
   always_comb begin
      pend_nxt = (pending & ~(clr_evt ? clr_mask : '0)) | (set_evt ? set_mask : '0);
      irq_nxt  = irq;
      if (set_evt && ((pend_nxt & enable) != '0)) begin
         irq_nxt = 1'b1;
      end else if (clr_evt && (pend_nxt == '0) && (enable != '0)) begin
         irq_nxt = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= '0;
         enable  <= '0;
         irq     <= 1'b0;
      end else begin
         pending <= pend_nxt;
         irq     <= irq_nxt;
         if (en_we) begin
            enable <= en_wdata;
         end
      end
   end

   // R5
   set_bits_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> ((pending & $past(set_mask)) == $past(set_mask)));

   // R6
   clear_bits_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt && !set_evt) |=> ((pending & $past(clr_mask)) == '0));

   // R5
   irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(set_evt));

   // R6
   irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ($past(clr_evt) && (pending == '0)));

   // R7
   enable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_we && !set_evt && !clr_evt) |=> $stable(irq));

endmodule

// File: rtl/core_ipi_mailbox.sv
module core_ipi_mailbox #(
   parameter int unsigned W     = 32,
   parameter int unsigned WORDS = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [2:0]   idx,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata
);

   generate
      if (WORDS < 1 || WORDS > 8) begin : g_bad_words
         $error("core_ipi_mailbox: WORDS must lie in 1..8");
      end
   endgenerate

   logic [W-1:0] word_q [WORDS];

   generate
      for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q[gi] <= '0;
            end else if (we && (idx == 3'(gi))) begin
               word_q[gi] <= wdata;
            end
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (idx == 3'(i)) rdata = word_q[i];
      end
   end

   // R8
   mbox_write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (32'(idx) < WORDS)) |=> (word_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/core_ipi_sender.sv
module core_ipi_sender #(
   parameter int unsigned W         = 32,
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned TGT_LO    = 16,
   parameter int unsigned TGT_W     = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_we,
   input  logic [W-1:0]      send_wdata,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [CORE_W-1:0] out_core,
   output logic [W-1:0]      out_mask
);

   localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int unsigned VEC_W  = $clog2(W);
   localparam logic [TGT_W:0] CORE_LIMIT = (TGT_W + 1)'(NUM_CORES);

   generate
      if (NUM_CORES < 1 || NUM_CORES > (1 << TGT_W)) begin : g_bad_cores
         $error("core_ipi_sender: NUM_CORES out of range of target field");
      end
      if (TGT_LO + TGT_W > W) begin : g_bad_field
         $error("core_ipi_sender: target field exceeds word");
      end
   endgenerate

   logic [TGT_W-1:0] tgt;
   logic [VEC_W-1:0] vec;
   logic             tgt_ok;
   logic             slot_free;
   logic             take;
   logic             unused_send_bits;

   assign tgt              = send_wdata[TGT_LO +: TGT_W];
   assign vec              = send_wdata[VEC_W-1:0];
   assign tgt_ok           = {1'b0, tgt} < CORE_LIMIT;
   assign slot_free        = !out_valid || out_ready;
   assign take             = send_we && tgt_ok && slot_free;
   assign unused_send_bits = ^send_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_core  <= '0;
         out_mask  <= '0;
      end else if (take) begin
         out_valid <= 1'b1;
         out_core  <= tgt[CORE_W-1:0];
         out_mask  <= {{(W-1){1'b0}}, 1'b1} << vec;
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R11
   hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_core) && $stable(out_mask)));

   // R9
   mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_mask) == 1));

   // R10
   bad_target_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (send_we && !tgt_ok && !out_valid) |=> !out_valid);

endmodule

// File: rtl/core_ipi_block.sv
module core_ipi_block #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned NUM_CORES  = 4,
   parameter int unsigned MBOX_WORDS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_valid,
   input  logic                 reg_write,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 in_set_valid,
   input  logic [31:0]          in_set_mask,
   output logic                 out_set_valid,
   input  logic                 out_set_ready,
   output logic [((NUM_CORES > 1) ? $clog2(NUM_CORES) : 1)-1:0] out_set_core,
   output logic [31:0]          out_set_mask,
   output logic                 irq_o
);

   import core_ipi_pkg::*;

   localparam int unsigned W = WORD_W;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("core_ipi_block: ADDR_W must cover the 8-bit window");
      end
   endgenerate

   logic [5:0]   word_idx;
   reg_sel_e     sel;
   logic         wr;
   logic         loc_set_we;
   logic         set_evt;
   logic [W-1:0] set_mask;
   logic         clr_evt;
   logic         en_we;
   logic         mbox_we;
   logic         send_we;
   logic [W-1:0] pending;
   logic [W-1:0] enable;
   logic [W-1:0] mbox_rdata;
   logic         unused_addr_bits;

   assign word_idx         = reg_addr[7:2];
   assign unused_addr_bits = ^reg_addr;
   assign sel              = decode_word(word_idx);
   assign wr               = reg_valid && reg_write;
   assign loc_set_we       = wr && (sel == SEL_SET);
   assign clr_evt          = wr && (sel == SEL_CLEAR);
   assign en_we            = wr && (sel == SEL_ENABLE);
   assign mbox_we          = wr && (sel == SEL_MBOX);
   assign send_we          = wr && (sel == SEL_SEND);
   assign set_evt          = loc_set_we || in_set_valid;
   assign set_mask         = (loc_set_we ? reg_wdata : '0) | (in_set_valid ? in_set_mask : '0);

   core_ipi_pending #(.W(W)) u_pending (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (set_evt),
      .set_mask (set_mask),
      .clr_evt  (clr_evt),
      .clr_mask (reg_wdata),
      .en_we    (en_we),
      .en_wdata (reg_wdata),
      .pending  (pending),
      .enable   (enable),
      .irq      (irq_o)
   );

   core_ipi_mailbox #(.W(W), .WORDS(MBOX_WORDS)) u_mailbox (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mbox_we),
      .idx   (word_idx[2:0]),
      .wdata (reg_wdata),
      .rdata (mbox_rdata)
   );

   core_ipi_sender #(.W(W), .NUM_CORES(NUM_CORES)) u_sender (
      .clk        (clk),
      .rst_n      (rst_n),
      .send_we    (send_we),
      .send_wdata (reg_wdata),
      .out_ready  (out_set_ready),
      .out_valid  (out_set_valid),
      .out_core   (out_set_core),
      .out_mask   (out_set_mask)
   );

   always_comb begin
      unique case (sel)
         SEL_PEND:   reg_rdata = pending;
         SEL_ENABLE: reg_rdata = enable;
         SEL_MBOX:   reg_rdata = mbox_rdata;
         default:    reg_rdata = '0;
      endcase
   end

   // R3
   pend_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (sel == SEL_PEND) && !in_set_valid) |=> $stable(pending));

   // R12
   incoming_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_set_valid && loc_set_we) |=>
         ((pending & ($past(in_set_mask) | $past(reg_wdata))) == ($past(in_set_mask) | $past(reg_wdata))));

endmodule

// File: tb/core_ipi_block_bench.sv
module core_ipi_block_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NCORES     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        in_set_valid = 1'b0;
   logic [31:0] in_set_mask = '0;
   logic        out_set_valid;
   logic        out_set_ready = 1'b0;
   logic [1:0]  out_set_core;
   logic [31:0] out_set_mask;
   logic        irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // bench model
   logic [31:0] m_pend, m_en, m_mask;
   logic [31:0] m_mbox [8];
   logic        m_irq, m_valid;
   logic [1:0]  m_core;

   always #(CLK_PERIOD/2) clk = ~clk;

   core_ipi_block #(.ADDR_W(12), .NUM_CORES(NCORES), .MBOX_WORDS(8)) u_core_ipi_block (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_valid     (reg_valid),
      .reg_write     (reg_write),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .in_set_valid  (in_set_valid),
      .in_set_mask   (in_set_mask),
      .out_set_valid (out_set_valid),
      .out_set_ready (out_set_ready),
      .out_set_core  (out_set_core),
      .out_set_mask  (out_set_mask),
      .irq_o         (irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [11:0] a);
      logic [5:0] w;
      w = a[7:2];
      if (w == 6'h00) return m_pend;
      if (w == 6'h01) return m_en;
      if (w[5:3] == 3'b001) return m_mbox[w[2:0]];
      return 32'h0;
   endfunction

   task automatic model_edge(input logic v, input logic w, input logic [11:0] a,
                             input logic [31:0] d, input logic iv, input logic [31:0] im,
                             input logic rdy);
      logic [5:0]  wi;
      logic        swr, cwr, sevt;
      logic [31:0] smask, nxt;
      logic        take;
      wi    = a[7:2];
      swr   = v && w && (wi == 6'h02);
      cwr   = v && w && (wi == 6'h03);
      sevt  = swr || iv;
      smask = (swr ? d : 32'h0) | (iv ? im : 32'h0);
      nxt   = (m_pend & ~(cwr ? d : 32'h0)) | smask;
      if (sevt && ((nxt & m_en) != 0)) m_irq = 1'b1;
      else if (cwr && (nxt == 0) && (m_en != 0)) m_irq = 1'b0;
      m_pend = nxt;
      if (v && w && wi == 6'h01) m_en = d;
      if (v && w && wi[5:3] == 3'b001) m_mbox[wi[2:0]] = d;
      take = v && w && (wi == 6'h10) && (d[25:16] < NCORES) && (!m_valid || rdy);
      if (take) begin
         m_valid = 1'b1;
         m_core  = d[17:16];
         m_mask  = 32'h1 << d[4:0];
      end else if (m_valid && rdy) begin
         m_valid = 1'b0;
      end
   endtask

   task automatic check_outs(input string tag);
      chk({tag, " irq"}, {31'h0, irq_o}, {31'h0, m_irq});
      chk({tag, " out_valid"}, {31'h0, out_set_valid}, {31'h0, m_valid});
      if (m_valid) begin
         chk({tag, " out_core"}, {30'h0, out_set_core}, {30'h0, m_core});
         chk({tag, " out_mask"}, out_set_mask, m_mask);
      end
   endtask

   task automatic step(input string tag, input logic v, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic iv, input logic [31:0] im,
                       input logic rdy);
      @(negedge clk);
      reg_valid = v; reg_write = w; reg_addr = a; reg_wdata = d;
      in_set_valid = iv; in_set_mask = im; out_set_ready = rdy;
      #1;
      if (v && !w) chk({tag, " rdata"}, reg_rdata, model_read(a));
      model_edge(v, w, a, d, iv, im, rdy);
      @(posedge clk);
      #(CLK_PERIOD/4);
      check_outs(tag);
   endtask

   task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
      step(tag, 1'b1, 1'b1, a, d, 1'b0, 32'h0, 1'b0);
   endtask

   task automatic rd(input string tag, input logic [11:0] a);
      step(tag, 1'b1, 1'b0, a, 32'h0, 1'b0, 32'h0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      m_pend = 0; m_en = 0; m_mask = 0; m_irq = 0; m_valid = 0; m_core = 0;
      for (int i = 0; i < 8; i++) m_mbox[i] = 0;
      void'($urandom(32'd20240917));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd("R1", 12'h000);
      rd("R1", 12'h004);
      rd("R1", 12'h020);
      rd("R1", 12'h03C);

      // R3 pending is read-only
      wr("R3", 12'h000, 32'hFFFF_FFFF);
      rd("R3", 12'h000);

      // R5 set with nothing enabled keeps irq low
      wr("R5", 12'h008, 32'h0000_0001);
      rd("R5", 12'h000);
      // R7 enable alone does not raise
      wr("R7", 12'h004, 32'h0000_0001);
      chk("R7 irq held low", {31'h0, irq_o}, 32'h0);
      // R5 a zero set write re-evaluates and raises
      wr("R5", 12'h008, 32'h0);
      chk("R5 irq raised", {31'h0, irq_o}, 32'h1);

      // R6 clear with enable zero leaves irq up
      wr("R6", 12'h004, 32'h0);
      wr("R6", 12'h00C, 32'h0000_0001);
      chk("R6 irq held", {31'h0, irq_o}, 32'h1);
      wr("R6", 12'h004, 32'h0000_00FF);
      wr("R6", 12'h008, 32'h0000_0006);
      wr("R6", 12'h00C, 32'h0000_0002);
      chk("R6 partial clear keeps irq", {31'h0, irq_o}, 32'h1);
      wr("R6", 12'h00C, 32'h0000_0004);
      chk("R6 irq dropped", {31'h0, irq_o}, 32'h0);

      // R4 write-only offsets read zero
      rd("R4", 12'h008);
      rd("R4", 12'h00C);
      rd("R4", 12'h040);

      // R2 unmapped and aliased addresses
      wr("R2", 12'h044, 32'hDEAD_BEEF);
      rd("R2", 12'h044);
      rd("R2", 12'h010);
      rd("R2", 12'hA04);
      wr("R2", 12'h714, 32'h1234_5678);
      rd("R2", 12'h004);

      // R8 mailbox words
      for (int i = 0; i < 8; i++) wr("R8", 12'(12'h020 + 4 * i), 32'hA5A5_0000 + 32'(i * 17));
      for (int i = 7; i >= 0; i--) rd("R8", 12'(12'h020 + 4 * i));

      // R12 incoming set merged with local set, and racing a clear
      wr("R12", 12'h004, 32'hFFFF_FFFF);
      step("R12", 1'b1, 1'b1, 12'h008, 32'h0000_0020, 1'b1, 32'h0000_0010, 1'b0);
      rd("R12", 12'h000);
      step("R12", 1'b1, 1'b1, 12'h00C, 32'h0000_0030, 1'b1, 32'h0000_0010, 1'b0);
      rd("R12", 12'h000);
      chk("R12 irq kept", {31'h0, irq_o}, 32'h1);

      // R9 send, R11 held and collision dropped
      wr("R9", 12'h040, 32'h0003_001F);
      chk("R9 mask", out_set_mask, 32'h8000_0000);
      wr("R11", 12'h040, 32'h0001_0002);
      chk("R11 core held", {30'h0, out_set_core}, 32'h3);
      step("R11", 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 32'h0, 1'b1);
      chk("R11 released", {31'h0, out_set_valid}, 32'h0);
      wr("R9", 12'h040, 32'h0000_0000);
      step("R11", 1'b1, 1'b1, 12'h040, 32'h0002_0005, 1'b0, 32'h0, 1'b1);
      chk("R11 back-to-back", out_set_mask, 32'h0000_0020);
      step("R11", 1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 32'h0, 1'b1);

      // R10 out of range targets
      wr("R10", 12'h040, 32'h0004_0001);
      wr("R10", 12'h040, 32'h03FF_0001);
      chk("R10 no request", {31'h0, out_set_valid}, 32'h0);

      // random traffic
      for (int n = 0; n < 600; n++) begin
         logic [5:0]  wi;
         logic [11:0] a;
         logic [31:0] d, im;
         logic        v, w, iv, rdy;
         int          pick;
         pick = $urandom % 9;
         case (pick)
            0: wi = 6'h00; 1: wi = 6'h01; 2: wi = 6'h02; 3: wi = 6'h03;
            4: wi = 6'h10; 5: wi = 6'h11;
            default: wi = 6'(8 + ($urandom % 8));
         endcase
         a   = {4'($urandom), wi, 2'b00};
         v   = ($urandom % 5) != 0;
         w   = $urandom % 2;
         d   = $urandom;
         if (wi == 6'h02) d = ($urandom % 3 == 0) ? 32'h0 : (32'h1 << ($urandom % 32));
         if (wi == 6'h10) d = {6'h0, 10'($urandom % 6), 16'($urandom)};
         iv  = ($urandom % 4) == 0;
         im  = 32'h1 << ($urandom % 32);
         rdy = $urandom % 2;
         step("R5/R6/R9/R11/R12 random", v, w, a, d, iv, im, rdy);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule